// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter with a small 32-bit register interface. Software programs a timeout length, arms the counter and must reload it before it runs out. The counter advances on a slow tick (nominally 32 kHz), with one timeout unit equal to 2^PRE_W ticks (512 by default). A timeout of N seconds is therefore N×64 units, and N may range from 1 to 31.

Every write must carry a fixed key or an exact code word. A write without it is dropped, so a stray store cannot disarm the watchdog or change its length. When the counter runs out, the block either requests a system reset for a fixed number of clock cycles or raises a level interrupt. A dual setting does both. An auto-reload setting makes it run again without software help. A separate register forces an immediate software reset. The reset request can also be driven onto an external pin with a selectable polarity.

Top module: `kwdog_top`

## Requirements
- R1: A write to the control register (offset 0x00) takes effect only when bits [31:24] equal 0x22. Any other write leaves the control fields and the counter unchanged.
- R2: Control bits are: 0 run, 1 pin polarity (1 = active high), 2 pin enable, 3 interrupt on expiry, 4 auto-reload, 6 dual action. Reading offset 0x00 returns these bits with all other bits zero. Reads of offsets 0x08 and 0x14 return zero.
- R3: A write to the length register (offset 0x04) takes effect only when bits [4:0] equal 0x08. The length is held in bits [31:5] and reads back in the same place, with bits [4:0] zero.
- R4: When run goes from 0 to 1, the counter loads the full length. With a tick every cycle, expiry becomes visible at the outputs on the (length×2^PRE_W + 1)-th rising edge after the arming write's edge. A length of zero never expires.
- R5: Writing exactly 0x1971 to offset 0x08 reloads the full length, restarts the tick prescaler and clears the interrupt. Any other value written there has no effect.
- R6: Clearing run freezes the counter. Setting run again counts the full length afresh.
- R7: On expiry with bit 3 clear, rst_req_o is held high for RST_CYCLES clock cycles. With bit 3 set, irq_o rises and stays high until a reload, and no reset is requested. With bit 6 set, both happen.
- R8: With auto-reload set, the counter reloads on expiry and expires again after another full length. Without it, the counter stops after one expiry.
- R9: Writing exactly 0x1209 to offset 0x14 raises rst_req_o on the next clock edge, for RST_CYCLES cycles. Any other value written there has no effect.
- R10: With the pin enabled, ext_rst_o shows the reset request at the selected polarity. When the pin is disabled or no reset is active, ext_rst_o sits at the inactive level (low for active high, high for active low).
- R11: After reset, control reads 0, length reads DEF_LEN<<5, and rst_req_o and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow tick enable, one cycle per tick |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 8 | Byte offset for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data for addr_i |
| rst_req_o | output | 1 | Active-high system reset request |
| ext_rst_o | output | 1 | External reset pin, polarity selected |
| irq_o | output | 1 | Expiry interrupt, held until reload |

## Verification
The arming edge or reload edge is taken as edge zero. Expiry is registered on edge length×2^PRE_W, and the reset, pin and interrupt change on the following edge. A software reset shows on the edge that takes the write. A reset pulse stays high for RST_CYCLES edges. Read data is valid one edge after the address is presented. The bench drives on falling edges and samples on the falling edge after the edge where each change is due. It checks the edge just before as well, so both an early and a late response are caught.

// File: rtl/kwdog_pkg.sv
`timescale 1ns/1ps
package kwdog_pkg;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int KEYLEN_W = 5;
  localparam int LEN_W = DW - KEYLEN_W;

  localparam logic [AW-1:0] OFF_CTRL  = 8'h00;
  localparam logic [AW-1:0] OFF_LEN   = 8'h04;
  localparam logic [AW-1:0] OFF_KICK  = 8'h08;
  localparam logic [AW-1:0] OFF_SWRST = 8'h14;

  localparam logic [7:0]          CTRL_KEY   = 8'h22;
  localparam logic [KEYLEN_W-1:0] LEN_KEY    = 5'h08;
  localparam logic [DW-1:0]       KICK_CODE  = 32'h0000_1971;
  localparam logic [DW-1:0]       SWRST_CODE = 32'h0000_1209;

  typedef struct packed {
    logic dual;
    logic auto_rl;
    logic irq_sel;
    logic pin_en;
    logic pol_hi;
    logic run;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [DW-1:0] w);
    ctrl_t c;
    c.run     = w[0];
    c.pol_hi  = w[1];
    c.pin_en  = w[2];
    c.irq_sel = w[3];
    c.auto_rl = w[4];
    c.dual    = w[6];
    return c;
  endfunction

  function automatic logic [DW-1:0] ctrl_to_word(input ctrl_t c);
    logic [DW-1:0] w;
    w    = '0;
    w[0] = c.run;
    w[1] = c.pol_hi;
    w[2] = c.pin_en;
    w[3] = c.irq_sel;
    w[4] = c.auto_rl;
    w[6] = c.dual;
    return w;
  endfunction
endpackage

// File: rtl/kwdog_count.sv
`timescale 1ns/1ps
module kwdog_count #(
  parameter int LEN_W = 27,
  parameter int PRE_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic             auto_rl_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             expire_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             unit_end;
  logic             step;

  assign step = run_i && tick_i && (cnt_q != '0);

  generate
    if (PRE_W == 0) begin : g_nopre
      assign unit_end = step;
    end else begin : g_pre
      localparam logic [PRE_W-1:0] PRE_MAX = '1;
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk_i) begin
        if (rst_i || load_i) begin
          pre_q <= '0;
        end else if (step) begin
          pre_q <= (pre_q == PRE_MAX) ? '0 : pre_q + 1'b1;
        end
      end
      assign unit_end = step && (pre_q == PRE_MAX);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (load_i) begin
        cnt_q <= len_i;
      end else if (unit_end) begin
        if (cnt_q == LEN_W'(1)) begin
          expire_o <= 1'b1;
          cnt_q    <= auto_rl_i ? len_i : '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kwdog_outs.sv
`timescale 1ns/1ps
module kwdog_outs #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic expire_i,
  input  logic swrst_i,
  input  logic kick_i,
  input  logic irq_sel_i,
  input  logic dual_i,
  input  logic pin_en_i,
  input  logic pol_hi_i,
  output logic rst_req_o,
  output logic ext_rst_o,
  output logic irq_o
);
  localparam int HW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [HW-1:0] HOLD_LOAD = HW'(RST_CYCLES - 1);

  logic          fire;
  logic          irq_set;
  logic [HW-1:0] hold_q;

  assign fire    = (expire_i && (!irq_sel_i || dual_i)) || swrst_i;
  assign irq_set = expire_i && (irq_sel_i || dual_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hold_q    <= '0;
      rst_req_o <= 1'b0;
    end else if (fire) begin
      hold_q    <= HOLD_LOAD;
      rst_req_o <= 1'b1;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end else begin
      rst_req_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || kick_i) begin
      irq_o <= 1'b0;
    end else if (irq_set) begin
      irq_o <= 1'b1;
    end
  end

  always_comb begin
    if (pin_en_i) begin
      ext_rst_o = pol_hi_i ? rst_req_o : !rst_req_o;
    end else begin
      ext_rst_o = !pol_hi_i;
    end
  end
endmodule

// File: rtl/kwdog_regs.sv
`timescale 1ns/1ps
module kwdog_regs
  import kwdog_pkg::*;
#(
  parameter logic [LEN_W-1:0] DEF_LEN = 27'd1984
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output ctrl_t            ctrl_o,
  output logic [LEN_W-1:0] len_o,
  output logic             start_o,
  output logic             kick_o,
  output logic             swrst_o
);
  logic  ctrl_wr;
  logic  len_wr;
  ctrl_t ctrl_nx;

  assign ctrl_nx = ctrl_from_word(wdata_i);
  assign ctrl_wr = wr_en_i && (addr_i == OFF_CTRL) && (wdata_i[DW-1:DW-8] == CTRL_KEY);
  assign len_wr  = wr_en_i && (addr_i == OFF_LEN) && (wdata_i[KEYLEN_W-1:0] == LEN_KEY);
  assign kick_o  = wr_en_i && (addr_i == OFF_KICK) && (wdata_i == KICK_CODE);
  assign swrst_o = wr_en_i && (addr_i == OFF_SWRST) && (wdata_i == SWRST_CODE);
  assign start_o = ctrl_wr && ctrl_nx.run && !ctrl_o.run;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_o <= '0;
    end else if (ctrl_wr) begin
      ctrl_o <= ctrl_nx;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      len_o <= DEF_LEN;
    end else if (len_wr) begin
      len_o <= wdata_i[DW-1:KEYLEN_W];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_o <= '0;
    end else begin
      unique case (addr_i)
        OFF_CTRL: rdata_o <= ctrl_to_word(ctrl_o);
        OFF_LEN:  rdata_o <= {len_o, {KEYLEN_W{1'b0}}};
        default:  rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/kwdog_top.sv
`timescale 1ns/1ps
module kwdog_top
  import kwdog_pkg::*;
#(
  parameter int PRE_W      = 9,
  parameter int RST_CYCLES = 16,
  parameter int DEF_LEN    = 1984
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rst_req_o,
  output logic          ext_rst_o,
  output logic          irq_o
);
  ctrl_t            ctrl_w;
  logic [LEN_W-1:0] len_w;
  logic             start_w;
  logic             kick_w;
  logic             swrst_w;
  logic             expire_w;

  kwdog_regs #(
    .DEF_LEN (LEN_W'(DEF_LEN))
  ) u_regs (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ctrl_o  (ctrl_w),
    .len_o   (len_w),
    .start_o (start_w),
    .kick_o  (kick_w),
    .swrst_o (swrst_w)
  );

  kwdog_count #(
    .LEN_W (LEN_W),
    .PRE_W (PRE_W)
  ) u_count (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tick_i    (tick_i),
    .run_i     (ctrl_w.run),
    .load_i    (start_w || kick_w),
    .auto_rl_i (ctrl_w.auto_rl),
    .len_i     (len_w),
    .expire_o  (expire_w)
  );

  kwdog_outs #(
    .RST_CYCLES (RST_CYCLES)
  ) u_outs (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .expire_i  (expire_w),
    .swrst_i   (swrst_w),
    .kick_i    (kick_w),
    .irq_sel_i (ctrl_w.irq_sel),
    .dual_i    (ctrl_w.dual),
    .pin_en_i  (ctrl_w.pin_en),
    .pol_hi_i  (ctrl_w.pol_hi),
    .rst_req_o (rst_req_o),
    .ext_rst_o (ext_rst_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/kwdog_chk.sv
`timescale 1ns/1ps
module kwdog_chk
  import kwdog_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             wr_en_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic             rst_req_o,
  input logic             irq_o,
  input ctrl_t            ctrl_w,
  input logic [LEN_W-1:0] len_w
);
  localparam int CW = $clog2(RST_CYCLES + 2);
  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hi_cnt_q <= '0;
    end else if (rst_req_o) begin
      if (hi_cnt_q != CW'(RST_CYCLES)) hi_cnt_q <= hi_cnt_q + 1'b1;
    end else begin
      hi_cnt_q <= '0;
    end
  end

  AST_CTRL_KEY: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i == OFF_CTRL && wdata_i[31:24] != CTRL_KEY) |=> $stable(ctrl_w)); // R1

  AST_CTRL_RD_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(addr_i) == OFF_CTRL) |-> (rdata_o[31:7] == '0 && rdata_o[5] == 1'b0)); // R2

  AST_LEN_KEY: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i == OFF_LEN && wdata_i[4:0] != LEN_KEY) |=> $stable(len_w)); // R3

  AST_KICK_CLR_IRQ: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i == OFF_KICK && wdata_i == KICK_CODE) |=> !irq_o); // R5

  AST_RST_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_req_o) |-> (hi_cnt_q == CW'(RST_CYCLES))); // R7

  AST_SWRST_FIRE: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i == OFF_SWRST && wdata_i == SWRST_CODE) |=> rst_req_o); // R9
endmodule

bind kwdog_top kwdog_chk #(
  .RST_CYCLES (RST_CYCLES)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .rst_req_o (rst_req_o),
  .irq_o     (irq_o),
  .ctrl_w    (ctrl_w),
  .len_w     (len_w)
);

// File: tb/kwdog_top_tb.sv
`timescale 1ns/1ps
module kwdog_top_tb;
  localparam int PRE_W = 2;
  localparam int RST_CYCLES = 4;
  localparam int DEF_LEN = 1984;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req, ext_rst, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kwdog_top #(.PRE_W(PRE_W), .RST_CYCLES(RST_CYCLES), .DEF_LEN(DEF_LEN)) u_dut (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req), .ext_rst_o(ext_rst), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] d;
    logic [7:0]  ra;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 32'h2200_005E, 8'h00, 32'h0000_005E}, // R2 fields stored
    '{8'h00, 32'h2200_007E, 8'h00, 32'h0000_005E}, // R2 bit 5 not kept
    '{8'h00, 32'h2300_0001, 8'h00, 32'h0000_005E}, // R1 wrong key
    '{8'h00, 32'h2200_0080, 8'h00, 32'h0000_0000}, // R2 bit 7 not kept
    '{8'h04, 32'h0000_0068, 8'h04, 32'h0000_0060}, // R3 length 3
    '{8'h04, 32'h0000_0069, 8'h04, 32'h0000_0060}, // R3 wrong key
    '{8'h04, 32'h0000_01E8, 8'h04, 32'h0000_01E0}, // R3 length 15
    '{8'h04, 32'hFFFF_FFE0, 8'h04, 32'h0000_01E0}, // R3 key zero
    '{8'h08, 32'h0000_1971, 8'h08, 32'h0000_0000}, // R2 reload reads zero
    '{8'h00, 32'h2100_0040, 8'h00, 32'h0000_0000}  // R1 wrong key
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(8'h00, 32'h2200_0000);
    wr(8'h08, 32'h0000_1971);
    wait_n(RST_CYCLES + 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 rst_req", 32'(rst_req), 0);
    chk("R11 irq", 32'(irq), 0);
    chk("R10 idle pin", 32'(ext_rst), 1);
    rd(8'h00, v); chk("R11 ctrl", v, 0);
    rd(8'h04, v); chk("R11 len", v, 32'(DEF_LEN) << 5);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].a, VEC[i].d);
      rd(VEC[i].ra, v);
      chk($sformatf("table %0d", i), v, VEC[i].e);
    end
    wr(8'h04, 32'h0000_0068); // length 3 units = 12 ticks

    // R4 R7 R10 R8: reset mode, pin active high
    wr(8'h00, 32'h2200_0007);
    wait_n(12); chk("R4 not yet", 32'(rst_req), 0);
    wait_n(1);  chk("R4 expiry rst", 32'(rst_req), 1);
    chk("R10 pin high", 32'(ext_rst), 1);
    chk("R7 no irq", 32'(irq), 0);
    wait_n(3);  chk("R7 hold end", 32'(rst_req), 1);
    wait_n(1);  chk("R7 released", 32'(rst_req), 0);
    chk("R10 pin idle low", 32'(ext_rst), 0);
    wait_n(20); chk("R8 single shot", 32'(rst_req), 0);
    quiesce();

    // R10 active-low pin
    wr(8'h00, 32'h2200_0005);
    chk("R10 idle high", 32'(ext_rst), 1);
    wait_n(13); chk("R10 pin low", 32'(ext_rst), 0);
    wait_n(4);  chk("R10 pin back", 32'(ext_rst), 1);
    quiesce();

    // R7 interrupt mode, R5 clear
    wr(8'h00, 32'h2200_0009);
    wait_n(13); chk("R7 irq", 32'(irq), 1);
    chk("R7 no rst", 32'(rst_req), 0);
    wait_n(10); chk("R7 irq held", 32'(irq), 1);
    wr(8'h08, 32'h0000_1971);
    chk("R5 irq cleared", 32'(irq), 0);
    quiesce();

    // R7 dual
    wr(8'h00, 32'h2200_0049);
    wait_n(13); chk("R7 dual irq", 32'(irq), 1);
    chk("R7 dual rst", 32'(rst_req), 1);
    quiesce();

    // R8 auto reload
    wr(8'h00, 32'h2200_0011);
    wait_n(13); chk("R8 first", 32'(rst_req), 1);
    wait_n(11); chk("R8 gap", 32'(rst_req), 0);
    wait_n(1);  chk("R8 second", 32'(rst_req), 1);
    quiesce();

    // R5 reload postpones expiry
    wr(8'h00, 32'h2200_0001);
    wait_n(7);
    wr(8'h08, 32'h0000_1971);
    wait_n(5);  chk("R5 postponed", 32'(rst_req), 0);
    wait_n(7);  chk("R5 not yet", 32'(rst_req), 0);
    wait_n(1);  chk("R5 reload expiry", 32'(rst_req), 1);
    quiesce();

    // R5 wrong reload value ignored
    wr(8'h00, 32'h2200_0001);
    wait_n(3);
    wr(8'h08, 32'h0000_1970);
    wait_n(8);  chk("R5 bad code early", 32'(rst_req), 0);
    wait_n(1);  chk("R5 bad code ignored", 32'(rst_req), 1);
    quiesce();

    // R6 freeze and full restart
    wr(8'h00, 32'h2200_0001);
    wait_n(5);
    wr(8'h00, 32'h2200_0000);
    wait_n(30); chk("R6 frozen", 32'(rst_req), 0);
    wr(8'h00, 32'h2200_0001);
    wait_n(7);  chk("R6 full length", 32'(rst_req), 0);
    wait_n(5);  chk("R6 not yet", 32'(rst_req), 0);
    wait_n(1);  chk("R6 expiry", 32'(rst_req), 1);
    quiesce();

    // R1 keyless arm ignored
    wr(8'h00, 32'h2300_0001);
    wait_n(20); chk("R1 no arm", 32'(rst_req), 0);
    rd(8'h00, v); chk("R1 ctrl kept", v, 0);

    // R9 software reset
    wr(8'h14, 32'h0000_1208);
    chk("R9 bad code", 32'(rst_req), 0);
    wr(8'h14, 32'h0000_1209);
    chk("R9 immediate", 32'(rst_req), 1);
    wait_n(3);  chk("R9 held", 32'(rst_req), 1);
    wait_n(1);  chk("R9 released", 32'(rst_req), 0);

    // R4 zero length never expires
    wr(8'h04, 32'h0000_0008);
    wr(8'h00, 32'h2200_0009);
    wait_n(40); chk("R4 zero rst", 32'(rst_req), 0);
    chk("R4 zero irq", 32'(irq), 0);
    quiesce();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule